// File: doc/BRIEF.md
# Chainable Serial Command Port for a Sixteen-Channel Gray-Level Driver

This block is the host-facing serial front end of a sixteen-output dimming driver. A host drives a data line, a bit clock and a framing strobe. Every rising bit-clock edge shifts one bit into a 16-bit shift register. The register's top bit drives the serial output, so several drivers can be chained, each output feeding the next driver's data input. Both the bit clock and the strobe are sampled as ordinary synchronous inputs in the system clock domain.

A strobe pulse with no bit-clock edges inside it marks the shift register as a 16-bit command. The commands are:

| Command | Code |
|---|---|
| Software clear | 0x0001 |
| Display word write | 0x0084 |
| Settings write | 0x0034 |
| Settings read | 0x0038 |
| Fault flag read | 0x003C |

The two write commands each take a second strobe-framed word, and that word is the payload. A strobe that spans 8 to 16 bit-clock edges is a global latch instead. Sixteen display words are gathered in a buffer chain. They reach the gray-level outputs, which feed a PWM engine outside this block, only when a global latch arrives.

The settings register supplies three fields: a current reference, a fault-sense mode and a repeat-mode flag. Read commands load a register into the shift register, and the host then clocks the value out, most significant bit first.

Top module: `led_chain_port`

## Requirements
- R1: After synchronous reset the following are all zero: `ser_out`, `gray_q`, `latch_pulse`, `cur_ref`, `err_mode` and `auto_mode`.
- R2: Each rising `ser_clk` edge shifts `ser_data` into bit 0 of the shift register, and `ser_out` always shows bit 15. A word shifted in most significant bit first therefore emerges on `ser_out` unchanged over the next 16 edges.
- R3: A strobe pulse with no `ser_clk` edge inside it, arriving while no payload is pending, decodes the shift register as a command. A code outside the five listed codes changes nothing and leaves no payload pending.
- R4: After code 0x0084, the next edge-free strobe pushes the shift register into a 16-word buffer chain. The newest word goes to channel 0, and every older word moves up one channel. After sixteen such writes the first word sits at channel 15. `gray_q` does not change on a push.
- R5: A strobe pulse that contains between 8 and 16 `ser_clk` edges, inclusive, is a global latch. It copies all buffers to `gray_q` (channel n at bits [16n+15:16n]) and raises `latch_pulse` for exactly one cycle. Pulses containing 1 to 7 edges, or more than 16, are ignored.
- R6: After code 0x0034, the next edge-free strobe stores the shift register as the settings word. Its fields are: `cur_ref` = bits [7:0], `err_mode` = bits [9:8] (01 checks for open outputs, 10 checks for shorted outputs, 00 and 11 turn checking off), `auto_mode` = bit 10, and bits [15:11] reserved.
- R7: Code 0x0038 loads the full settings word into the shift register. The next 16 `ser_clk` edges shift it out on `ser_out`, most significant bit first.
- R8: Code 0x003C loads the fault word into the shift register. Bit n equals `err_sense[n]` when `err_mode` is 01 or 10, and reads zero when `err_mode` is 00 or 11.
- R9: Code 0x0001 clears the settings word, the shift register and all sixteen buffers. `gray_q` keeps its value until the next global latch, which then drives all zeros.
- R10: While a payload is pending, the next edge-free strobe treats the shift register as data even when its value equals a command code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, sampled; its rising edges shift data |
| ser_data | input | 1 | Serial data in |
| ser_strobe | input | 1 | Framing strobe, sampled |
| err_sense | input | 16 | Per-output fault sense, 1 = fault |
| ser_out | output | 1 | Serial data out for chaining (shift register bit 15) |
| gray_q | output | 256 | Latched gray words, channel n at [16n+15:16n] |
| latch_pulse | output | 1 | One-cycle pulse on each global latch |
| cur_ref | output | 8 | Current reference field |
| err_mode | output | 2 | Fault-sense mode field |
| auto_mode | output | 1 | Repeat-mode field |

## Verification
Strobe pulses that fall just outside the 8 to 16 edge window are the hardest case to reach from the ports. Pulses of 5 and 17 edges must leave `gray_q` unchanged. Both are placed right after a fresh push, so any wrong latch would show up as changed gray data. A payload word that equals the settings-write code is hard to reach for the same reason. It is sent while a display write is pending, then followed by a settings check and a latch to confirm how it was taken. A reference model in the bench tracks the shift queue, the buffer chain and the settings word cycle by cycle, and compares them with the outputs on every clock.

// File: rtl/led_chain_pkg.sv
// Shared constants for the serial command port: word width, channel count,
// command codes and the payload-pending state type.
package led_chain_pkg;
    localparam int WORD_W  = 16;
    localparam int CHAN_N  = 16;

    localparam logic [WORD_W-1:0] CODE_CLEAR  = 16'h0001;
    localparam logic [WORD_W-1:0] CODE_DISP   = 16'h0084;
    localparam logic [WORD_W-1:0] CODE_SET_WR = 16'h0034;
    localparam logic [WORD_W-1:0] CODE_SET_RD = 16'h0038;
    localparam logic [WORD_W-1:0] CODE_ERR_RD = 16'h003C;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_DISP = 2'd1,
        PEND_SET  = 2'd2
    } pend_e;
endpackage

// File: rtl/lc_serial_front.sv
// Serial front end.
// Samples the bit clock and the strobe in the system clock domain and
// detects their edges. Shifts data most significant bit first, and counts
// bit-clock edges inside each strobe pulse. On a strobe fall it raises
// either a command event (no edges counted) or a latch event (count inside
// the latch window).
// Assumes ser_clk and ser_strobe are synchronous to clk and stay in each
// state for at least one clk period.
module lc_serial_front #(
    parameter int W         = 16,
    parameter int LATCH_MIN = 8,
    parameter int LATCH_MAX = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic         ser_strobe,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] sr_q,
    output logic         ser_out,
    output logic         cmd_evt,
    output logic         latch_evt
);
    localparam int CNT_W = $clog2(LATCH_MAX + 2);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(LATCH_MIN);
    localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(LATCH_MAX);

    logic             clk_q, stb_q;
    logic             clk_rise, stb_rise, stb_fall;
    logic [CNT_W-1:0] edge_cnt;

    // Hold the previous samples of the bit clock and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            clk_q <= ser_clk;
            stb_q <= ser_strobe;
        end
    end

    assign clk_rise = ser_clk & ~clk_q;
    assign stb_rise = ser_strobe & ~stb_q;
    assign stb_fall = ~ser_strobe & stb_q;

    // Count bit-clock edges inside the current strobe pulse (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (stb_fall) begin
            edge_cnt <= '0;
        end else if (stb_rise) begin
            edge_cnt <= {{(CNT_W-1){1'b0}}, clk_rise};
        end else if (ser_strobe && clk_rise && edge_cnt != CNT_TOP) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign cmd_evt   = stb_fall && (edge_cnt == '0);
    assign latch_evt = stb_fall && (edge_cnt >= WIN_LO) && (edge_cnt <= WIN_HI);

    // Shift register: a parallel load takes priority over a shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_en) begin
            sr_q <= load_val;
        end else if (clk_rise) begin
            sr_q <= {sr_q[W-2:0], ser_data};
        end
    end

    assign ser_out = sr_q[W-1];

    // R2: a plain shift moves the bit below the top onto the serial output.
    p_shift_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rise && !load_en) |=> (ser_out == $past(sr_q[W-2])));

    // R5: a command event and a latch event never coincide.
    p_evt_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_evt && latch_evt));
endmodule

// File: rtl/lc_cmd_ctrl.sv
// Command decoder and settings register.
// On each command event: completes a pending payload if there is one,
// otherwise decodes the shift register. Requests parallel loads of the
// shift register for the reads and for the software clear.
// Assumes cmd_evt is a single-cycle event from the serial front end.
module lc_cmd_ctrl
    import led_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_evt,
    input  logic [WORD_W-1:0] sr_q,
    input  logic [WORD_W-1:0] err_word,
    output logic              load_en,
    output logic [WORD_W-1:0] load_val,
    output logic              push_en,
    output logic              sw_clear,
    output logic [WORD_W-1:0] cfg_q
);
    pend_e pend_q, pend_d;
    logic  cfg_wr;

    // Decode the event into loads, pushes, clears and the next pending state.
    always_comb begin
        load_en  = 1'b0;
        load_val = '0;
        push_en  = 1'b0;
        sw_clear = 1'b0;
        cfg_wr   = 1'b0;
        pend_d   = pend_q;
        if (cmd_evt) begin
            case (pend_q)
                PEND_DISP: begin
                    push_en = 1'b1;
                    pend_d  = PEND_NONE;
                end
                PEND_SET: begin
                    cfg_wr = 1'b1;
                    pend_d = PEND_NONE;
                end
                default: begin
                    case (sr_q)
                        CODE_CLEAR: begin
                            sw_clear = 1'b1;
                            load_en  = 1'b1;
                            load_val = '0;
                        end
                        CODE_DISP:   pend_d = PEND_DISP;
                        CODE_SET_WR: pend_d = PEND_SET;
                        CODE_SET_RD: begin
                            load_en  = 1'b1;
                            load_val = cfg_q;
                        end
                        CODE_ERR_RD: begin
                            load_en  = 1'b1;
                            load_val = err_word;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // Track which payload, if any, the next strobe completes.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= PEND_NONE;
        else        pend_q <= pend_d;
    end

    // Settings register: cleared by reset or software clear, else written.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clear) cfg_q <= '0;
        else if (cfg_wr)        cfg_q <= sr_q;
    end

    // R6: the settings only change on a command event.
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_evt |=> $stable(cfg_q));

    // R9: a decoded clear code leaves the settings at zero.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_evt && pend_q == PEND_NONE && sr_q == CODE_CLEAR) |=> (cfg_q == '0));
endmodule

// File: rtl/lc_disp_bank.sv
// Display buffer chain and latched gray words.
// A push moves every buffer up one channel and writes the new word into
// channel 0. A latch copies every buffer into the gray registers and
// raises a one-cycle pulse.
// Assumes push and latch never occur in the same cycle.
module lc_disp_bank #(
    parameter int CH = 16,
    parameter int W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push_en,
    input  logic [W-1:0]    push_val,
    input  logic            latch_evt,
    output logic [CH*W-1:0] gray_flat,
    output logic            latch_pulse
);
    logic [W-1:0] buf_q  [CH];
    logic [W-1:0] gray_q [CH];

    // Buffer chain: clear all words, or push a new word at channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < CH; i++) buf_q[i] <= '0;
        end else if (push_en) begin
            buf_q[0] <= push_val;
            for (int i = 1; i < CH; i++) buf_q[i] <= buf_q[i-1];
        end
    end

    // Gray registers: take the whole chain on a latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CH; i++) gray_q[i] <= '0;
        end else if (latch_evt) begin
            for (int i = 0; i < CH; i++) gray_q[i] <= buf_q[i];
        end
    end

    // Latch pulse: one cycle after each latch event.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_pulse <= 1'b0;
        else        latch_pulse <= latch_evt;
    end

    for (genvar g = 0; g < CH; g++) begin : g_pack
        assign gray_flat[g*W +: W] = gray_q[g];
    end

    // R4: the gray outputs only change on a latch.
    p_gray_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_evt |=> $stable(gray_flat));

    // R5: the latch pulse lasts exactly one cycle.
    p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> !latch_pulse);
endmodule

// File: rtl/lc_err_capture.sv
// Fault flag capture.
// Registers the per-output sense inputs when a check mode (01 or 10) is
// selected, and holds zero otherwise.
// Assumes err_sense is already synchronous to clk.
module lc_err_capture #(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [CH-1:0] err_sense,
    output logic [CH-1:0] err_word
);
    logic check_on;
    assign check_on = mode[0] ^ mode[1];

    // Capture the sense inputs each cycle while checking is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_word <= '0;
        else if (check_on) err_word <= err_sense;
        else               err_word <= '0;
    end

    // R8: a disabled mode yields an all-zero fault word.
    p_err_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |=> (err_word == '0));
endmodule

// File: rtl/led_chain_port.sv
// Top level of the chainable serial command port.
// Connects the serial front end, the command decoder, the display buffer
// bank and the fault capture, and splits the settings word into its fields.
// Assumes all inputs are synchronous to clk.
module led_chain_port
    import led_chain_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_data,
    input  logic                     ser_strobe,
    input  logic [CHAN_N-1:0]        err_sense,
    output logic                     ser_out,
    output logic [CHAN_N*WORD_W-1:0] gray_q,
    output logic                     latch_pulse,
    output logic [7:0]               cur_ref,
    output logic [1:0]               err_mode,
    output logic                     auto_mode
);
    logic [WORD_W-1:0] sr_q, load_val, cfg_q;
    logic [CHAN_N-1:0] err_word;
    logic              load_en, cmd_evt, latch_evt, push_en, sw_clear;
    logic              cfg_unused;

    lc_serial_front #(.W(WORD_W), .LATCH_MIN(8), .LATCH_MAX(16)) u_front (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .load_en(load_en), .load_val(load_val),
        .sr_q(sr_q), .ser_out(ser_out), .cmd_evt(cmd_evt), .latch_evt(latch_evt)
    );

    lc_cmd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .sr_q(sr_q),
        .err_word(err_word), .load_en(load_en), .load_val(load_val),
        .push_en(push_en), .sw_clear(sw_clear), .cfg_q(cfg_q)
    );

    lc_disp_bank #(.CH(CHAN_N), .W(WORD_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clear(sw_clear), .push_en(push_en),
        .push_val(sr_q), .latch_evt(latch_evt), .gray_flat(gray_q),
        .latch_pulse(latch_pulse)
    );

    lc_err_capture #(.CH(CHAN_N)) u_err (
        .clk(clk), .rst_n(rst_n), .mode(cfg_q[9:8]), .err_sense(err_sense),
        .err_word(err_word)
    );

    assign cur_ref    = cfg_q[7:0];
    assign err_mode   = cfg_q[9:8];
    assign auto_mode  = cfg_q[10];
    assign cfg_unused = ^cfg_q[WORD_W-1:11];
endmodule

// File: tb/led_chain_port_tb.sv
// Bench: a behavioural reference model (queues) updated on every clock and
// compared on every falling edge, plus directed checks per requirement.
module led_chain_port_tb;
    localparam int CH = 16;
    localparam int W  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
    logic [CH-1:0] err_sense = '0;
    logic ser_out, latch_pulse, auto_mode;
    logic [CH*W-1:0] gray_q;
    logic [7:0] cur_ref;
    logic [1:0] err_mode;

    int n_chk = 0, n_err = 0, n_pulse = 0;
    bit done = 1'b0;

    led_chain_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .err_sense(err_sense), .ser_out(ser_out),
        .gray_q(gray_q), .latch_pulse(latch_pulse), .cur_ref(cur_ref),
        .err_mode(err_mode), .auto_mode(auto_mode)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_sr[$];
    logic [15:0] m_buf[$];
    logic [15:0] m_gray[16];
    logic [15:0] m_cfg, m_errq;
    int          m_pend, m_cnt;
    bit          m_clk_q, m_stb_q, m_pulse;

    function automatic void m_load(input logic [15:0] v);
        m_sr.delete();
        for (int i = 15; i >= 0; i--) m_sr.push_back(v[i]);
    endfunction

    function automatic logic [15:0] m_word();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) v[15-i] = m_sr[i];
        return v;
    endfunction

    function automatic void m_reset();
        m_load(16'h0);
        m_buf.delete();
        for (int i = 0; i < 16; i++) begin
            m_buf.push_back(16'h0);
            m_gray[i] = 16'h0;
        end
        m_cfg = 0; m_errq = 0; m_pend = 0; m_cnt = 0;
        m_clk_q = 0; m_stb_q = 0; m_pulse = 0;
    endfunction

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            bit rise, sfall, srise, ld, pl;
            logic [15:0] lv, old_cfg, old_err, word;
            rise = ser_clk && !m_clk_q;
            sfall = !ser_strobe && m_stb_q;
            srise = ser_strobe && !m_stb_q;
            old_cfg = m_cfg; old_err = m_errq; word = m_word();
            ld = 0; lv = 0; pl = 0;
            if (sfall) begin
                if (m_cnt == 0) begin
                    if (m_pend == 1) begin
                        m_buf.push_front(word); void'(m_buf.pop_back()); m_pend = 0;
                    end else if (m_pend == 2) begin
                        m_cfg = word; m_pend = 0;
                    end else if (word == 16'h0001) begin
                        m_cfg = 0; ld = 1; lv = 0;
                        for (int i = 0; i < 16; i++) m_buf[i] = 16'h0;
                    end else if (word == 16'h0084) m_pend = 1;
                    else if (word == 16'h0034) m_pend = 2;
                    else if (word == 16'h0038) begin ld = 1; lv = old_cfg; end
                    else if (word == 16'h003C) begin ld = 1; lv = old_err; end
                end else if (m_cnt >= 8 && m_cnt <= 16) begin
                    for (int i = 0; i < 16; i++) m_gray[i] = m_buf[i];
                    pl = 1;
                end
                m_cnt = 0;
            end else if (srise) m_cnt = rise ? 1 : 0;
            else if (ser_strobe && rise && m_cnt < 31) m_cnt++;
            if (ld) m_load(lv);
            else if (rise) begin void'(m_sr.pop_front()); m_sr.push_back(ser_data); end
            m_errq = (old_cfg[9:8] == 2'b01 || old_cfg[9:8] == 2'b10) ? err_sense : 16'h0;
            m_pulse = pl; m_clk_q = ser_clk; m_stb_q = ser_strobe;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [CH*W-1:0] eg;
            for (int i = 0; i < 16; i++) eg[i*W +: W] = m_gray[i];
            chk("R2 ser_out vs model", {31'b0, ser_out}, {31'b0, m_sr[0]});
            chk("R4 gray_q vs model", {31'b0, gray_q == eg}, 32'd1);
            chk("R5 latch_pulse vs model", {31'b0, latch_pulse}, {31'b0, m_pulse});
            chk("R6 settings vs model", {21'b0, auto_mode, err_mode, cur_ref}, {21'b0, m_cfg[10:0]});
            if (latch_pulse) n_pulse++;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic shift_bit(input logic b, output logic o);
        @(negedge clk); o = ser_out; ser_data = b; ser_clk = 1'b1;
        @(negedge clk); ser_clk = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] w);
        logic o;
        for (int i = 15; i >= 0; i--) shift_bit(w[i], o);
    endtask

    task automatic read_word(output logic [15:0] w);
        logic o;
        for (int i = 15; i >= 0; i--) begin shift_bit(1'b0, o); w[i] = o; end
    endtask

    task automatic strobe();
        @(negedge clk); ser_strobe = 1'b1;
        @(negedge clk); ser_strobe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic glatch(input int n);
        logic o;
        @(negedge clk); ser_strobe = 1'b1;
        for (int i = 0; i < n; i++) shift_bit(1'b0, o);
        @(negedge clk); ser_strobe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd(input logic [15:0] c);
        put_word(c); strobe();
    endtask

    task automatic cmd_data(input logic [15:0] c, input logic [15:0] d);
        cmd(c); put_word(d); strobe();
    endtask

    function automatic logic [31:0] ch(input int n);
        return {16'h0, gray_q[n*W +: W]};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [15:0] rd;
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ser_out after reset", {31'b0, ser_out}, 32'd0);
        chk("R1 gray_q after reset", {31'b0, gray_q == '0}, 32'd1);
        chk("R1 latch_pulse after reset", {31'b0, latch_pulse}, 32'd0);
        chk("R1 settings after reset", {21'b0, auto_mode, err_mode, cur_ref}, 32'd0);

        put_word(16'hA5C3); read_word(rd);
        chk("R2 pass-through word", {16'h0, rd}, 32'h0000A5C3);

        cmd_data(16'h0034, 16'h0512);
        chk("R6 cur_ref", {24'h0, cur_ref}, 32'h12);
        chk("R6 err_mode", {30'h0, err_mode}, 32'h1);
        chk("R6 auto_mode", {31'h0, auto_mode}, 32'h1);

        cmd(16'h0038); read_word(rd);
        chk("R7 settings read-back", {16'h0, rd}, 32'h0512);

        for (int k = 0; k < 16; k++) cmd_data(16'h0084, 16'h1000 + 16'(k));
        chk("R4 gray held before latch", {31'b0, gray_q == '0}, 32'd1);
        p0 = n_pulse;
        glatch(8);
        chk("R4 first word on channel 15", ch(15), 32'h1000);
        chk("R4 last word on channel 0", ch(0), 32'h100F);
        chk("R4 channel 7", ch(7), 32'h1008);
        chk("R5 one latch pulse", n_pulse - p0, 32'd1);

        cmd_data(16'h0084, 16'hBEEF);
        glatch(5);
        chk("R5 five-edge strobe ignored", ch(0), 32'h100F);
        glatch(17);
        chk("R5 seventeen-edge strobe ignored", ch(0), 32'h100F);
        glatch(16);
        chk("R5 sixteen-edge latch ch0", ch(0), 32'hBEEF);
        chk("R5 sixteen-edge latch ch15", ch(15), 32'h1001);

        err_sense = 16'h8421;
        repeat (3) @(negedge clk);
        cmd(16'h003C); read_word(rd);
        chk("R8 open-check flags", {16'h0, rd}, 32'h8421);
        cmd_data(16'h0034, 16'h0300);
        cmd(16'h003C); read_word(rd);
        chk("R8 mode 11 flags zero", {16'h0, rd}, 32'h0);
        cmd_data(16'h0034, 16'h0200);
        cmd(16'h003C); read_word(rd);
        chk("R8 short-check flags", {16'h0, rd}, 32'h8421);

        cmd_data(16'h0084, 16'h0034);
        chk("R10 code-valued payload left settings", {22'h0, err_mode, cur_ref}, 32'h200);
        glatch(10);
        chk("R10 payload reached channel 0", ch(0), 32'h0034);
        chk("R10 chain shifted to channel 1", ch(1), 32'hBEEF);

        cmd(16'h0055);
        chk("R3 unknown code keeps settings", {22'h0, err_mode, cur_ref}, 32'h200);
        chk("R3 unknown code keeps gray", ch(0), 32'h0034);
        cmd(16'h0038); read_word(rd);
        chk("R3 no payload pending after unknown code", {16'h0, rd}, 32'h0200);

        cmd(16'h0001);
        chk("R9 clear zeroes settings", {21'b0, auto_mode, err_mode, cur_ref}, 32'd0);
        chk("R9 clear zeroes shift register", {31'b0, ser_out}, 32'd0);
        chk("R9 gray kept until latch", ch(0), 32'h0034);
        glatch(8);
        chk("R9 latch after clear gives zero", {31'b0, gray_q == '0}, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog R1-all actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule